// File: doc/BRIEF.md
# Three-Wire Serial Nonvolatile Memory Slave

This block is the device side of a serial memory. The host selects it with a chip-select line, clocks it with a shift clock, and moves data in and out on two data lines. Every instruction starts with a one start bit. An opcode and an address follow. Depending on the opcode, data bits come next or read data goes back out. The storage holds 16384 bits. A strap input picks one of two word layouts: 1024 words of 16 bits or 2048 elements of 8 bits. Write-type operations are gated by a write-enable latch and take a self-timed interval counted in system clocks. While that interval runs, the block reports busy or ready on the data output.

All pins are sampled in the system clock domain after a synchronizer, and the block acts on each rising edge of the shift clock. A central state machine moves through the states ST_IDLE, ST_OPC, ST_ADDR, ST_DATA, ST_READ and ST_DONE:

- ST_IDLE goes to ST_OPC on a one bit while not busy.
- ST_OPC goes to ST_ADDR after two bits.
- ST_ADDR goes to ST_READ for a read, or to ST_DATA for a write or fill.
- ST_ADDR goes to ST_DONE for erase, enable, disable and clear-all.
- ST_DATA goes to ST_DONE after the last data bit.
- Any state returns to ST_IDLE whenever chip select is low.

Top module: `nvm3w_slave`

## Requirements
- R1: After reset the write-enable latch is clear and do_oe is low. do_oe is low whenever cs is low.
- R2: When org_drv is low the x16 layout is used, whatever org_lvl is (weak pull-up). When org_drv is high, org_lvl high selects x16 with 10 address bits and org_lvl low selects x8 with 11 address bits. In x8, element address bit 0 picks the upper byte (1) or the lower byte (0) of word address[10:1]. The layout is taken at the start bit.
- R3: di is sampled on each rising edge of sk. Zeros before the start bit are skipped. The start bit 1 is followed by a 2-bit opcode, MSB first (10 read, 01 write, 11 erase, 00 extended), then the address, MSB first. On a read, the edge that carries the last address bit makes DO drive a 0. Each later edge then presents the next data bit, MSB first.
- R4: A read keeps going while sk runs. After the last bit of one element, the next edge gives the MSB of the element at address+1. The address wraps to 0 after the highest address.
- R5: A write (01) takes 16 or 8 data bits, MSB first, and replaces the addressed element. No erase is needed beforehand.
- R6: Erase (11) sets the addressed element to all ones. The extended opcode uses the top two address bits as a subcommand: 10 sets every word to all ones, and 01 takes one data element and writes it to every element.
- R7: Extended subcommand 11 sets the write-enable latch and 00 clears it. Write, erase and both fill subcommands change nothing while the latch is clear.
- R8: A write-type operation starts on its last bit and stays busy for WRITE_CYCLES clocks. If cs is dropped and raised again, DO is driven low while busy and high once ready. It stays driven until the next start bit.
- R9: While busy, start bits are ignored, so any instruction sent during that time has no effect on the storage.
- R10: If cs goes low before the last bit of a write, the write is aborted. The storage is unchanged and no busy period starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial shift clock |
| di | input | 1 | Serial data into the block |
| org_drv | input | 1 | High when the layout strap is driven; low models a floating strap |
| org_lvl | input | 1 | Level of the layout strap when driven (1 = x16, 0 = x8) |
| do_data | output | 1 | Serial data or ready/busy status out |
| do_oe | output | 1 | Output enable for do_data (low = high impedance) |

## Verification
The hardest situation to reach from the pins is a complete instruction that arrives inside a busy window. That includes the status drive it must leave in place and the storage it must leave untouched. The bench raises the write time so that a full write frame fits inside one busy interval. It deselects and reselects during that interval, sends a whole write, and afterwards reads the target back unchanged. A write cut off by chip select one bit before the end is driven the same way, between constrained random sequences that mix both layouts, all enable states and both sequential-read wraps.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_DATA,
        ST_READ,
        ST_DONE
    } nvm_state_e;

    typedef enum logic [1:0] {
        MOP_NONE,
        MOP_WORD,
        MOP_ALL
    } mem_op_e;

    localparam logic [1:0] OPC_EXT   = 2'b00;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_ERASE = 2'b11;

    localparam logic [1:0] SUB_WDIS  = 2'b00;
    localparam logic [1:0] SUB_WRALL = 2'b01;
    localparam logic [1:0] SUB_ERALL = 2'b10;
    localparam logic [1:0] SUB_WEN   = 2'b11;

endpackage

// File: rtl/nvm_pin_sync.sv
module nvm_pin_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[0] <= '0;
                    else        stg[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[i] <= '0;
                    else        stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/nvm_store.sv
module nvm_store
    import nvm_pkg::*;
#(
    parameter int WORDS = 1024,
    parameter int WIDTH = 16,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic             clk,
    input  mem_op_e          op,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] wmask,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        unique case (op)
            MOP_WORD: mem[waddr] <= (mem[waddr] & ~wmask) | (wdata & wmask);
            MOP_ALL: begin
                for (int i = 0; i < WORDS; i++) begin
                    mem[i] <= wdata;
                end
            end
            default: ;
        endcase
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/nvm_wr_timer.sv
module nvm_wr_timer #(
    parameter int CYCLES = 2000,
    localparam int TW    = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (start)      cnt <= TW'(CYCLES);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/nvm3w_slave.sv
module nvm3w_slave
    import nvm_pkg::*;
#(
    parameter int MEM_WORDS    = 1024,
    parameter int WORD_W       = 16,
    parameter int WRITE_CYCLES = 2000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    input  logic org_drv,
    input  logic org_lvl,
    output logic do_data,
    output logic do_oe
);
    localparam int AW16   = $clog2(MEM_WORDS);
    localparam int AW8    = AW16 + 1;
    localparam int BYTE_W = WORD_W / 2;
    localparam int CW     = $clog2(WORD_W + 1);

    // pin synchronisation and shift-clock edge
    logic [2:0] pins_s;
    logic       cs_s, sk_s, di_s, sk_d, sk_rise, fire;

    nvm_pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs, sk, di}),
        .q     (pins_s)
    );
    assign {cs_s, sk_s, di_s} = pins_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sk_d <= 1'b0;
        else        sk_d <= sk_s;
    end
    assign sk_rise = sk_s & ~sk_d;
    assign fire    = cs_s & sk_rise;

    // state and datapath registers
    nvm_state_e         state, state_nx;
    logic [CW-1:0]      bit_cnt, rd_left, dw;
    logic [1:0]         opc, top2;
    logic [AW8-1:0]     addr_sh, rd_addr;
    logic [WORD_W-1:0]  data_sh, rd_sh;
    logic               x16_q, wen_q, stat_q, do_bit;
    logic               org_mode, busy, addr_last, data_last;

    // derived values
    logic [AW8-1:0]     mode_mask, new_addr, new_addr_m, rd_next, rd_tgt, wr_elem;
    logic [WORD_W-1:0]  new_data, rd_aligned, wr_pattern, byte_mask;
    logic [AW16-1:0]    mem_raddr, mem_waddr;
    logic [WORD_W-1:0]  mem_rdata, mem_wdata, mem_wmask;
    mem_op_e            mem_op;
    logic               tmr_start, wen_set, wen_clr;

    function automatic logic [AW16-1:0] word_of(input logic [AW8-1:0] a, input logic m16);
        return m16 ? a[AW16-1:0] : a[AW8-1:1];
    endfunction

    assign org_mode   = ~org_drv | org_lvl;
    assign mode_mask  = x16_q ? AW8'({AW16{1'b1}}) : {AW8{1'b1}};
    assign new_addr   = {addr_sh[AW8-2:0], di_s};
    assign new_addr_m = new_addr & mode_mask;
    assign rd_next    = (rd_addr + 1'b1) & mode_mask;
    assign top2       = x16_q ? new_addr[AW16-1 -: 2] : new_addr[AW8-1 -: 2];
    assign dw         = x16_q ? CW'(WORD_W) : CW'(BYTE_W);
    assign addr_last  = (bit_cnt == (x16_q ? CW'(AW16 - 1) : CW'(AW8 - 1)));
    assign data_last  = (bit_cnt == dw - 1'b1);
    assign new_data   = {data_sh[WORD_W-2:0], di_s};

    // read path
    assign rd_tgt     = (state == ST_ADDR) ? new_addr_m : rd_next;
    assign mem_raddr  = word_of(rd_tgt, x16_q);
    assign rd_aligned = x16_q ? mem_rdata
                              : {(rd_tgt[0] ? mem_rdata[WORD_W-1:BYTE_W] : mem_rdata[BYTE_W-1:0]),
                                 {BYTE_W{1'b0}}};

    // write path
    assign wr_elem    = (state == ST_ADDR) ? new_addr_m : addr_sh;
    assign mem_waddr  = word_of(wr_elem, x16_q);
    assign byte_mask  = wr_elem[0] ? {{BYTE_W{1'b1}}, {BYTE_W{1'b0}}}
                                   : {{BYTE_W{1'b0}}, {BYTE_W{1'b1}}};
    assign mem_wmask  = x16_q ? {WORD_W{1'b1}} : byte_mask;
    assign wr_pattern = x16_q ? new_data : {new_data[BYTE_W-1:0], new_data[BYTE_W-1:0]};

    nvm_store #(.WORDS(MEM_WORDS), .WIDTH(WORD_W)) u_store (
        .clk   (clk),
        .op    (mem_op),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .wmask (mem_wmask),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    nvm_wr_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .busy  (busy)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        if (!cs_s) begin
            state_nx = ST_IDLE;
        end else if (sk_rise) begin
            unique case (state)
                ST_IDLE: if (di_s && !busy) state_nx = ST_OPC;
                ST_OPC:  if (bit_cnt == CW'(1)) state_nx = ST_ADDR;
                ST_ADDR: begin
                    if (addr_last) begin
                        case (opc)
                            OPC_READ:  state_nx = ST_READ;
                            OPC_WRITE: state_nx = ST_DATA;
                            OPC_ERASE: state_nx = ST_DONE;
                            default:   state_nx = (top2 == SUB_WRALL) ? ST_DATA : ST_DONE;
                        endcase
                    end
                end
                ST_DATA: if (data_last) state_nx = ST_DONE;
                ST_READ: state_nx = ST_READ;
                ST_DONE: state_nx = ST_DONE;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // instruction effects
    always_comb begin
        mem_op    = MOP_NONE;
        mem_wdata = {WORD_W{1'b1}};
        tmr_start = 1'b0;
        wen_set   = 1'b0;
        wen_clr   = 1'b0;
        if (fire) begin
            unique case (state)
                ST_ADDR: begin
                    if (addr_last) begin
                        case (opc)
                            OPC_ERASE: begin
                                if (wen_q) begin
                                    mem_op    = MOP_WORD;
                                    tmr_start = 1'b1;
                                end
                            end
                            OPC_EXT: begin
                                case (top2)
                                    SUB_WEN:  wen_set = 1'b1;
                                    SUB_WDIS: wen_clr = 1'b1;
                                    SUB_ERALL: begin
                                        if (wen_q) begin
                                            mem_op    = MOP_ALL;
                                            tmr_start = 1'b1;
                                        end
                                    end
                                    default: ;
                                endcase
                            end
                            default: ;
                        endcase
                    end
                end
                ST_DATA: begin
                    if (data_last && wen_q) begin
                        mem_op    = (opc == OPC_WRITE) ? MOP_WORD : MOP_ALL;
                        mem_wdata = wr_pattern;
                        tmr_start = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rd_left <= '0;
            opc     <= '0;
            addr_sh <= '0;
            rd_addr <= '0;
            data_sh <= '0;
            rd_sh   <= '0;
            x16_q   <= 1'b1;
            wen_q   <= 1'b0;
            stat_q  <= 1'b0;
            do_bit  <= 1'b0;
        end else begin
            if (wen_set)   wen_q  <= 1'b1;
            if (wen_clr)   wen_q  <= 1'b0;
            if (tmr_start) stat_q <= 1'b1;
            if (!cs_s) begin
                bit_cnt <= '0;
            end else if (sk_rise) begin
                unique case (state)
                    ST_IDLE: begin
                        if (di_s && !busy) begin
                            x16_q   <= org_mode;
                            bit_cnt <= '0;
                            opc     <= '0;
                            addr_sh <= '0;
                            stat_q  <= 1'b0;
                        end
                    end
                    ST_OPC: begin
                        opc     <= {opc[0], di_s};
                        bit_cnt <= (bit_cnt == CW'(1)) ? '0 : bit_cnt + 1'b1;
                    end
                    ST_ADDR: begin
                        addr_sh <= new_addr_m;
                        bit_cnt <= addr_last ? '0 : bit_cnt + 1'b1;
                        if (addr_last && opc == OPC_READ) begin
                            rd_addr <= new_addr_m;
                            rd_sh   <= rd_aligned;
                            rd_left <= dw;
                            do_bit  <= 1'b0;
                        end
                    end
                    ST_DATA: begin
                        data_sh <= new_data;
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                    ST_READ: begin
                        if (rd_left == '0) begin
                            rd_addr <= rd_next;
                            do_bit  <= rd_aligned[WORD_W-1];
                            rd_sh   <= {rd_aligned[WORD_W-2:0], 1'b0};
                            rd_left <= dw - 1'b1;
                        end else begin
                            do_bit  <= rd_sh[WORD_W-1];
                            rd_sh   <= {rd_sh[WORD_W-2:0], 1'b0};
                            rd_left <= rd_left - 1'b1;
                        end
                    end
                    ST_DONE: ;
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        do_oe   = cs_s & ((state == ST_READ) | ((state == ST_IDLE) & stat_q));
        do_data = (state == ST_READ) ? do_bit : ~busy;
    end
endmodule

// File: rtl/nvm3w_slave_chk.sv
module nvm3w_slave_chk
    import nvm_pkg::*;
#(
    parameter int WRITE_CYCLES = 2000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cs,
    input logic       do_oe,
    input logic       do_data,
    input logic       busy,
    input logic       wen_q,
    input mem_op_e    mem_op,
    input nvm_state_e state
);
    logic [31:0] busy_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_len <= '0;
        else if (busy) busy_len <= busy_len + 1'b1;
        else           busy_len <= '0;
    end

    AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs && !$past(cs) && !$past(cs, 2) && !$past(cs, 3)) |-> !do_oe); // R1

    AST_BUSY_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (do_oe && busy) |-> !do_data); // R8

    AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len == WRITE_CYCLES)); // R8

    AST_WRITE_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_op != MOP_NONE) |-> wen_q); // R7

    AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state != ST_OPC) |=> (state != ST_OPC)); // R9
endmodule

bind nvm3w_slave nvm3w_slave_chk #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs      (cs),
    .do_oe   (do_oe),
    .do_data (do_data),
    .busy    (busy),
    .wen_q   (wen_q),
    .mem_op  (mem_op),
    .state   (state)
);

// File: tb/nvm3w_slave_bench.sv
module nvm3w_slave_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WCYC       = 400;
    localparam int H          = 3;
    localparam int WATCHDOG   = 190000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0, org_drv = 1'b1, org_lvl = 1'b1;
    logic do_data, do_oe;

    nvm3w_slave #(.WRITE_CYCLES(WCYC)) u_nvm3w_slave (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
        .org_drv(org_drv), .org_lvl(org_lvl), .do_data(do_data), .do_oe(do_oe)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0, errors = 0;
    bit finished = 1'b0;
    logic last_do, last_oe;
    logic [15:0] model [1024];
    bit wen_m = 1'b0;
    bit x16 = 1'b1;

    function automatic int abits();
        return x16 ? 10 : 11;
    endfunction

    function automatic int dbits();
        return x16 ? 16 : 8;
    endfunction

    function automatic logic [15:0] exp_elem(input int a);
        if (x16) return model[a];
        return a[0] ? {8'h00, model[a >> 1][15:8]} : {8'h00, model[a >> 1][7:0]};
    endfunction

    task automatic put_elem(input int a, input logic [15:0] d);
        if (x16)       model[a] = d;
        else if (a[0]) model[a >> 1][15:8] = d[7:0];
        else           model[a >> 1][7:0]  = d[7:0];
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic set_org(input logic drv, input logic lvl);
        org_drv = drv;
        org_lvl = lvl;
        x16 = !drv || lvl;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        di = b;
        repeat (H) @(negedge clk);
        sk = 1'b1;
        repeat (H) @(negedge clk);
        sk = 1'b0;
        repeat (H) @(negedge clk);
        last_do = do_data;
        last_oe = do_oe;
    endtask

    task automatic cs_off();
        sk = 1'b0;
        di = 1'b0;
        cs = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_hdr(input logic [1:0] op, input int a, input int lead);
        cs = 1'b1;
        repeat (4) @(negedge clk);
        for (int i = 0; i < lead; i++) send_bit(1'b0);
        send_bit(1'b1);
        send_bit(op[1]);
        send_bit(op[0]);
        for (int i = abits() - 1; i >= 0; i--) send_bit(a[i]);
    endtask

    task automatic send_data(input logic [15:0] d);
        for (int i = dbits() - 1; i >= 0; i--) send_bit(d[i]);
    endtask

    task automatic wait_ready(input string req, input bit started);
        cs = 1'b1;
        repeat (4) @(negedge clk);
        if (started) begin
            chk(req, {14'd0, do_oe, do_data}, 16'h0002);
            for (int i = 0; i < WCYC + 50 && !do_data; i++) @(negedge clk);
            chk(req, {14'd0, do_oe, do_data}, 16'h0003);
        end else begin
            chk(req, {15'd0, do_oe}, 16'h0000);
        end
        cs_off();
    endtask

    task automatic do_write(input int a, input logic [15:0] d, input int lead);
        send_hdr(2'b01, a, lead);
        send_data(d);
        cs_off();
        if (wen_m) put_elem(a, d);
        wait_ready("R8", wen_m);
    endtask

    task automatic do_erase(input int a);
        send_hdr(2'b11, a, 0);
        cs_off();
        if (wen_m) put_elem(a, 16'hFFFF);
        wait_ready("R8", wen_m);
    endtask

    task automatic do_ext(input logic [1:0] sub, input logic [15:0] d);
        send_hdr(2'b00, int'(sub) << (abits() - 2), 0);
        if (sub == 2'b01) send_data(d);
        cs_off();
        if (sub == 2'b11) wen_m = 1'b1;
        if (sub == 2'b00) wen_m = 1'b0;
        if (sub == 2'b10 || sub == 2'b01) begin
            if (wen_m) begin
                for (int i = 0; i < 1024; i++)
                    model[i] = (sub == 2'b10) ? 16'hFFFF
                             : (x16 ? d : {d[7:0], d[7:0]});
            end
            wait_ready("R6", wen_m);
        end
    endtask

    task automatic do_read(input int a, input int n, input string req);
        int addr;
        logic [15:0] act;
        addr = a;
        send_hdr(2'b10, a, 0);
        chk("R3", {14'd0, last_oe, last_do}, 16'h0002);
        for (int w = 0; w < n; w++) begin
            act = '0;
            for (int b = 0; b < dbits(); b++) begin
                send_bit(1'b0);
                act = {act[14:0], last_do};
            end
            chk(req, act, exp_elem(addr));
            addr = (addr + 1) % (x16 ? 1024 : 2048);
        end
        cs_off();
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R1 watchdog act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned r;
        void'($urandom(32'd7919));
        for (int i = 0; i < 1024; i++) model[i] = 16'hFFFF;
        repeat (5) @(negedge clk);
        chk("R1", {15'd0, do_oe}, 16'h0000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        cs = 1'b1;
        repeat (6) @(negedge clk);
        chk("R1", {15'd0, do_oe}, 16'h0000);
        cs_off();

        // enable is clear after reset: a clear-all does nothing and starts no busy period
        send_hdr(2'b00, 2 << 8, 0);
        cs_off();
        wait_ready("R1", 1'b0);

        do_ext(2'b11, 16'h0);          // R7 enable
        do_ext(2'b10, 16'h0);          // R6 clear all
        do_read(0, 3, "R6");

        do_ext(2'b00, 16'h0);          // R7 disable
        do_write(5, 16'h1234, 0);
        do_erase(6);
        do_read(5, 1, "R7");

        do_ext(2'b11, 16'h0);
        do_write(5, 16'h1234, 2);
        do_read(5, 1, "R5");
        do_write(5, 16'hA5C3, 0);      // overwrite with no erase
        do_read(5, 1, "R5");

        set_org(1'b1, 1'b0);           // R2 x8
        do_write(11, 16'h007E, 1);
        do_read(11, 1, "R2");
        do_read(10, 2, "R2");
        set_org(1'b0, 1'b0);           // R2 floating strap selects x16
        do_read(5, 1, "R2");

        do_write(1023, 16'hBEEF, 0);
        do_read(1023, 2, "R4");        // wrap to 0
        set_org(1'b1, 1'b0);
        do_read(2047, 2, "R4");
        set_org(1'b1, 1'b1);

        do_erase(5);
        do_read(5, 1, "R6");

        // R9: a whole write sent during busy is ignored
        send_hdr(2'b01, 7, 0);
        send_data(16'h1111);
        cs_off();
        put_elem(7, 16'h1111);
        send_hdr(2'b01, 8, 0);
        send_data(16'h0000);
        chk("R9", {14'd0, last_oe, last_do}, 16'h0002);
        cs_off();
        wait_ready("R9", 1'b1);
        do_read(7, 2, "R9");

        // R10: deselect one bit before the end of a write
        send_hdr(2'b01, 9, 0);
        for (int i = 0; i < 15; i++) send_bit(1'b0);
        cs_off();
        chk("R10", {15'd0, do_oe}, 16'h0000);
        wait_ready("R10", 1'b0);
        do_read(9, 1, "R10");

        do_ext(2'b01, 16'h5A3C);       // R6 fill all
        do_read(300, 2, "R6");
        set_org(1'b1, 1'b0);
        do_ext(2'b01, 16'h00C7);
        do_read(77, 2, "R6");
        set_org(1'b1, 1'b1);

        for (int it = 0; it < 40; it++) begin
            r = $urandom();
            case (r % 8)
                0: set_org(1'b1, $urandom() % 2 == 0);
                1: do_ext(($urandom() % 4 == 0) ? 2'b00 : 2'b11, 16'h0);
                2, 3: do_write($urandom() % (x16 ? 1024 : 2048), 16'($urandom()), $urandom() % 3);
                4: do_erase($urandom() % (x16 ? 1024 : 2048));
                default: do_read($urandom() % (x16 ? 1024 : 2048), 1 + $urandom() % 2, "R3");
            endcase
        end
        do_ext(2'b11, 16'h0);
        do_write(123, 16'h0F0F, 0);
        do_read(122, 3, "R5");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule